// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes a 4-bit operation code and two operands. The second operand arrives already shifted, together with the carry bit the shifter produced. The block also takes the current N, Z, C and V condition flags and a set-flags request. One clock edge later it presents the operation's result, a strobe that says whether the result should be written to the destination register, and the new flag values.

The sixteen operations fall into two groups, and the flags behave differently in each:

- **Bitwise and move operations** take their carry from the shifter and leave the overflow flag untouched.
- **Add and subtract operations** take both carry and overflow from a single adder. Every subtraction is formed as an addition of the inverted subtrahend plus a carry-in. A carry of 1 after a subtraction therefore means no borrow occurred.

Four compare and test codes run an operation only to set the flags. They never request a write.

A separate input marks an instruction whose destination is the program counter. For such instructions the flag update is suppressed, but the result path works as for any other destination. Register reads, condition evaluation and program-counter handling all lie outside the block.

Top module: `dp_alu`

## Requirements
- R1: Bitwise codes produce the following results: AND (0000) gives a&b, EOR (0001) gives a^b, ORR (1100) gives a|b, and BIC (1110) gives a&~b.
- R2: MOV (1101) produces operand b and MVN (1111) produces ~b; operand a has no effect on either.
- R3: Arithmetic codes produce the following results, all modulo 2^32, where c is the incoming C flag: ADD (0100) gives a+b, ADC (0101) gives a+b+c, SUB (0010) gives a-b, RSB (0011) gives b-a, SBC (0110) gives a-b+c-1, and RSC (0111) gives b-a+c-1.
- R4: The write strobe is 0 for TST (1000), TEQ (1001), CMP (1010) and CMN (1011), and 1 for every other code.
- R5: Flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V. A bitwise or move code with set_flags=1 sets N to result bit 31, sets Z when the result is zero, copies shift_carry into C, and keeps V.
- R6: An arithmetic code with set_flags=1 sets C to the adder carry-out, which is 1 on a subtraction without borrow. It sets V on signed overflow, and sets N and Z from the result.
- R7: The four test codes update the flags even when set_flags is 0. TST and TEQ follow the bitwise rule; CMP and CMN follow the arithmetic rule and behave as SUB and ADD.
- R8: With set_flags=0, a non-test code returns the incoming flags unchanged.
- R9: With dest_pc=1, the flags output equals the incoming flags for every code. The result and the write strobe are unaffected.
- R10: Outputs are registered and appear one clock after the inputs. A synchronous reset clears the result, the write strobe and the flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (shifter output) |
| shift_carry | input | 1 | Carry-out from the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Request a flag update |
| dest_pc | input | 1 | Destination is the program counter; suppress the flag update |
| result | output | 32 | Registered operation result |
| result_we | output | 1 | Registered write request for the result |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
On every cycle, the assertions check the following against the previous cycle's inputs:

- the write strobe against the operation class;
- flag retention when no update is requested or the destination is the program counter;
- the way the shifter carry and the old V reach the flags of bitwise operations;
- N and Z against the registered result;
- the pass-through of MOV.

Adder carry and overflow values, the borrow sense of reverse and carry-using subtractions, and the exact result of each operation need known operand values. Only the bench's directed scenarios can show these, along with the reset state.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_EOR = 4'b0001,
    OP_SUB = 4'b0010,
    OP_RSB = 4'b0011,
    OP_ADD = 4'b0100,
    OP_ADC = 4'b0101,
    OP_SBC = 4'b0110,
    OP_RSC = 4'b0111,
    OP_TST = 4'b1000,
    OP_TEQ = 4'b1001,
    OP_CMP = 4'b1010,
    OP_CMN = 4'b1011,
    OP_ORR = 4'b1100,
    OP_MOV = 4'b1101,
    OP_BIC = 4'b1110,
    OP_MVN = 4'b1111
  } dp_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
  localparam int FLG_W = 4;

  // Compare/test class: flags only, no write-back.
  function automatic logic op_is_test(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  // Adder class: the six add/sub codes plus CMP and CMN.
  function automatic logic op_is_arith(input logic [3:0] op);
    return (op[3] == 1'b0 && op[2:1] != 2'b00) || (op[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/dp_addsub.sv
module dp_addsub
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_flag,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] in_x, in_y;
  logic             cin;
  logic [WIDTH:0]   wide;

  // Operand steering: subtraction is x + ~y + cin.
  always_comb begin
    in_x = op_a;
    in_y = op_b;
    cin  = 1'b0;
    unique case (opcode)
      OP_SUB, OP_CMP: begin in_y = ~op_b; cin = 1'b1;       end
      OP_RSB:         begin in_x = op_b;  in_y = ~op_a; cin = 1'b1; end
      OP_ADC:         begin cin = carry_flag;               end
      OP_SBC:         begin in_y = ~op_b; cin = carry_flag; end
      OP_RSC:         begin in_x = op_b;  in_y = ~op_a; cin = carry_flag; end
      default:        begin end
    endcase
  end

  always_comb begin
    wide      = {1'b0, in_x} + {1'b0, in_y} + {{WIDTH{1'b0}}, cin};
    sum       = wide[MSB:0];
    carry_out = wide[WIDTH];
    overflow  = (in_x[MSB] == in_y[MSB]) && (wide[MSB] != in_x[MSB]);
  end

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    unique case (opcode)
      OP_AND, OP_TST: res = op_a & op_b;
      OP_EOR, OP_TEQ: res = op_a ^ op_b;
      OP_ORR:         res = op_a | op_b;
      OP_MOV:         res = op_b;
      OP_BIC:         res = op_a & ~op_b;
      OP_MVN:         res = ~op_b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] res,
  input  logic             shift_carry,
  input  logic             add_carry,
  input  logic             add_ovf,
  input  logic [FLG_W-1:0] flags_in,
  input  logic             set_flags,
  input  logic             dest_pc,
  output logic [FLG_W-1:0] flags_next,
  output logic             write_req
);
  logic update;

  always_comb begin
    update     = !dest_pc && (set_flags || op_is_test(opcode));
    write_req  = !op_is_test(opcode);
    flags_next = flags_in;
    if (update) begin
      flags_next[FLG_N] = res[WIDTH-1];
      flags_next[FLG_Z] = (res == '0);
      if (op_is_arith(opcode)) begin
        flags_next[FLG_C] = add_carry;
        flags_next[FLG_V] = add_ovf;
      end else begin
        flags_next[FLG_C] = shift_carry;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             shift_carry,
  input  logic [3:0]       flags_in,
  input  logic             set_flags,
  input  logic             dest_pc,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);
  logic [WIDTH-1:0] add_sum, logic_res, res_mux;
  logic             add_c, add_v, we_nxt;
  logic [FLG_W-1:0] flags_nxt;

  dp_addsub #(.WIDTH(WIDTH)) u_add (
    .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .carry_flag(flags_in[FLG_C]),
    .sum(add_sum), .carry_out(add_c), .overflow(add_v)
  );

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .opcode(opcode), .op_a(op_a), .op_b(op_b), .res(logic_res)
  );

  assign res_mux = op_is_arith(opcode) ? add_sum : logic_res;

  dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .opcode(opcode), .res(res_mux), .shift_carry(shift_carry),
    .add_carry(add_c), .add_ovf(add_v), .flags_in(flags_in),
    .set_flags(set_flags), .dest_pc(dest_pc),
    .flags_next(flags_nxt), .write_req(we_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
    end else begin
      result    <= res_mux;
      result_we <= we_nxt;
      flags_out <= flags_nxt;
    end
  end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       opcode,
  input logic [WIDTH-1:0] op_b,
  input logic             shift_carry,
  input logic [3:0]       flags_in,
  input logic             set_flags,
  input logic             dest_pc,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic [3:0]       flags_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R4
  we_class_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst)) |-> (result_we == ($past(opcode[3:2]) != 2'b10)));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(set_flags) && $past(opcode[3:2]) != 2'b10)
      |-> (flags_out == $past(flags_in)));

  // R9
  pc_dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(dest_pc)) |-> (flags_out == $past(flags_in)));

  // R5
  logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(set_flags) && !$past(dest_pc) &&
     ($past(opcode) inside {4'b0000, 4'b0001, 4'b1100, 4'b1101, 4'b1110, 4'b1111}))
      |-> (flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0])));

  // R7
  test_nz_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(dest_pc) && $past(opcode[3:2]) == 2'b10)
      |-> (flags_out[3] == result[WIDTH-1] && flags_out[2] == (result == '0)));

  // R2
  mov_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(opcode) == 4'b1101) |-> (result == $past(op_b)));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .op_b(op_b),
  .shift_carry(shift_carry), .flags_in(flags_in), .set_flags(set_flags),
  .dest_pc(dest_pc), .result(result), .result_we(result_we),
  .flags_out(flags_out)
);

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  opcode;
  logic [31:0] op_a, op_b;
  logic        shift_carry;
  logic [3:0]  flags_in;
  logic        set_flags, dest_pc;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  dp_alu dut (
    .clk(clk), .rst(rst), .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .shift_carry(shift_carry), .flags_in(flags_in), .set_flags(set_flags),
    .dest_pc(dest_pc), .result(result), .result_we(result_we),
    .flags_out(flags_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge register, sample 1 ns later.
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] fl, input logic s, input logic pc);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc;
    flags_in = fl; set_flags = s; dest_pc = pc;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(4'b0100, 32'h1, 32'h1, 1'b1, 4'hF, 1'b1, 1'b0);
    check("R10 result", result, 32'h0);
    check("R10 we", {31'b0, result_we}, 32'h0);
    check("R10 flags", {28'b0, flags_out}, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_latency();
    apply(4'b1101, 32'h0, 32'h0000_0011, 1'b0, 4'h0, 1'b0, 1'b0);
    @(negedge clk);
    op_b = 32'h0000_0022;
    #1;
    check("R10 before edge", result, 32'h0000_0011);
    @(posedge clk); #1;
    check("R10 after edge", result, 32'h0000_0022);
  endtask

  task automatic t_bitwise();
    apply(4'b0000, 32'h8000_0001, 32'h8000_0000, 1'b0, 4'b0011, 1'b1, 1'b0);
    check("R1 AND", result, 32'h8000_0000);
    check("R5 AND flags", {28'b0, flags_out}, 32'h9);
    apply(4'b0001, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1, 4'b0000, 1'b1, 1'b0);
    check("R1 EOR", result, 32'hF00F_F00F);
    check("R5 EOR flags", {28'b0, flags_out}, 32'hA);
    apply(4'b1100, 32'h0000_00F0, 32'h0000_000F, 1'b0, 4'b0000, 1'b0, 1'b0);
    check("R1 ORR", result, 32'h0000_00FF);
    apply(4'b1110, 32'h0000_00FF, 32'h0000_000F, 1'b0, 4'b0000, 1'b0, 1'b0);
    check("R1 BIC", result, 32'h0000_00F0);
    check("R4 BIC we", {31'b0, result_we}, 32'h1);
  endtask

  task automatic t_moves();
    apply(4'b1101, 32'hDEAD_BEEF, 32'h0000_1234, 1'b0, 4'b0000, 1'b0, 1'b0);
    check("R2 MOV", result, 32'h0000_1234);
    apply(4'b1111, 32'h1234_5678, 32'h0000_0000, 1'b1, 4'b0001, 1'b1, 1'b0);
    check("R2 MVN", result, 32'hFFFF_FFFF);
    check("R5 MVN flags", {28'b0, flags_out}, 32'hB);
  endtask

  task automatic t_arith();
    apply(4'b0100, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b1, 1'b0);
    check("R3 ADD", result, 32'h8000_0000);
    check("R6 ADD ovf flags", {28'b0, flags_out}, 32'h9);
    apply(4'b0010, 32'h5, 32'h5, 1'b0, 4'b0000, 1'b1, 1'b0);
    check("R3 SUB zero", result, 32'h0);
    check("R6 SUB no borrow", {28'b0, flags_out}, 32'h6);
    apply(4'b0010, 32'h3, 32'h5, 1'b1, 4'b0011, 1'b1, 1'b0);
    check("R3 SUB neg", result, 32'hFFFF_FFFE);
    check("R6 SUB borrow", {28'b0, flags_out}, 32'h8);
    apply(4'b0011, 32'h3, 32'hA, 1'b0, 4'b0000, 1'b1, 1'b0);
    check("R3 RSB", result, 32'h7);
    check("R6 RSB flags", {28'b0, flags_out}, 32'h2);
    apply(4'b0101, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, 1'b1, 1'b0);
    check("R3 ADC", result, 32'h0);
    check("R6 ADC flags", {28'b0, flags_out}, 32'h6);
    apply(4'b0110, 32'hA, 32'h3, 1'b0, 4'b0000, 1'b1, 1'b0);
    check("R3 SBC c0", result, 32'h6);
    check("R6 SBC flags", {28'b0, flags_out}, 32'h2);
    apply(4'b0111, 32'h3, 32'hA, 1'b0, 4'b0010, 1'b1, 1'b0);
    check("R3 RSC c1", result, 32'h7);
    check("R6 RSC flags", {28'b0, flags_out}, 32'h2);
  endtask

  task automatic t_tests();
    apply(4'b1010, 32'h5, 32'h5, 1'b0, 4'b1001, 1'b0, 1'b0);
    check("R7 CMP flags", {28'b0, flags_out}, 32'h6);
    check("R4 CMP we", {31'b0, result_we}, 32'h0);
    apply(4'b1000, 32'hF0, 32'h0F, 1'b1, 4'b0001, 1'b0, 1'b0);
    check("R7 TST flags", {28'b0, flags_out}, 32'h7);
    check("R4 TST we", {31'b0, result_we}, 32'h0);
    apply(4'b1001, 32'h8000_0000, 32'h0, 1'b0, 4'b0000, 1'b0, 1'b0);
    check("R7 TEQ flags", {28'b0, flags_out}, 32'h8);
    check("R4 TEQ we", {31'b0, result_we}, 32'h0);
    apply(4'b1011, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b0, 1'b0);
    check("R7 CMN flags", {28'b0, flags_out}, 32'h6);
    check("R4 CMN we", {31'b0, result_we}, 32'h0);
  endtask

  task automatic t_hold();
    apply(4'b0100, 32'h7FFF_FFFF, 32'h1, 1'b1, 4'b0110, 1'b0, 1'b0);
    check("R8 ADD S=0 flags", {28'b0, flags_out}, 32'h6);
    check("R8 ADD S=0 result", result, 32'h8000_0000);
    apply(4'b0000, 32'h0, 32'h0, 1'b1, 4'b1000, 1'b0, 1'b0);
    check("R8 AND S=0 flags", {28'b0, flags_out}, 32'h8);
  endtask

  task automatic t_pc_dest();
    apply(4'b0010, 32'h5, 32'h5, 1'b0, 4'b1001, 1'b1, 1'b1);
    check("R9 SUB flags", {28'b0, flags_out}, 32'h9);
    check("R9 SUB result", result, 32'h0);
    check("R9 SUB we", {31'b0, result_we}, 32'h1);
    apply(4'b1010, 32'h1, 32'h2, 1'b0, 4'b0100, 1'b0, 1'b1);
    check("R9 CMP flags", {28'b0, flags_out}, 32'h4);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    opcode = 4'h0; op_a = '0; op_b = '0; shift_carry = 1'b0;
    flags_in = 4'h0; set_flags = 1'b0; dest_pc = 1'b0; rst = 1'b1;
    t_reset();
    t_latency();
    t_bitwise();
    t_moves();
    t_arith();
    t_tests();
    t_hold();
    t_pc_dest();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule